// File: doc/BRIEF.md
# Divided-Range Column Converter Controller

This block sequences one column of a display driver that uses a divided-range digital-to-analogue scheme. The upper bits of each data word pick one of several equal voltage intervals. The remaining bits are then converted one at a time by charging the column from one end of that interval or the other. With 2^M intervals and an N-bit serial stage, the result resolves M+N bits. In the default build, an 8-bit word is split two ways. Its top two bits choose one of four intervals, bounded by five reference levels. Its low six bits are sent out serially, so a conversion needs six charging cycles rather than eight.

A one-cycle load strobe captures the word while the block is idle. The interval index is held in a register for the whole conversion. The serial bits leave least significant first, one per clock. In each active cycle, exactly one reference switch is closed and the charge strobe is high. The switch is the lower bound of the chosen interval when the current bit is 0, and the upper bound when it is 1. A one-clock done pulse follows the last charging cycle.

Top module: `divrange_col_ctrl`

## Requirements
- R1: When `load_i` is high at a rising edge while the block is idle, `charge_o` is high for exactly the six cycles after that edge, then low.
- R2: The interval index is `data_i[7:6]` captured at load. Serial bits are taken from the captured `data_i[5:0]` least significant first: active cycle k (k = 0..5) uses bit k.
- R3: For interval index i, a serial bit of 0 enables reference i and a bit of 1 enables reference i+1. Bit j of `ref_en_o` is reference j, and reference 0 is the lowest level.
- R4: During every active cycle exactly one bit of `ref_en_o` is set. When idle, `ref_en_o` is all zero.
- R5: `done_o` is high for exactly one cycle: the cycle right after the sixth active cycle. At all other times it is low.
- R6: A load strobe or a change of `data_i` during a conversion has no effect on the running conversion.
- R7: A synchronous active-low reset clears all outputs at the next edge and abandons any conversion in progress.
- R8: A load accepted in the cycle that shows `done_o` starts a new conversion at once, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Load strobe; accepted only while idle |
| data_i | input | 8 | Parallel data word: [7:6] interval, [5:0] serial part |
| ref_en_o | output | 5 | One-hot reference switch enables, bit j = reference j |
| charge_o | output | 1 | High during each charging cycle |
| done_o | output | 1 | One-cycle pulse after the last charging cycle |

## Verification
Loading is registered, so the first charging cycle shows up one edge after the edge that samples `load_i`. Each following serial bit appears one edge later, and `done_o` appears on the seventh edge. The bench drives its inputs on falling edges and samples on the next falling edge. Each charging cycle is therefore checked against a value computed from the word and the cycle number. Mid-run strobes, back-to-back loads in the done cycle, and a reset during a conversion are each checked at the first falling edge after the rising edge they affect.

// File: rtl/drc_pkg.sv
// Package: shared types for the divided-range column controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package drc_pkg;

    // Sequencer phase: waiting for a word, or charging the column.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/drc_sequencer.sv
// Module: drc_sequencer
// Counts the serial charging cycles of one conversion and raises done.
// Assumes: start is only honoured while idle. SER_W >= 1.
module drc_sequencer
    import drc_pkg::*;
#(
    parameter int SER_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic start_o,
    output logic active_o,
    output logic last_o,
    output logic done_o
);

    localparam int CNT_W = $clog2(SER_W + 1);
    localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(SER_W - 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] left_q;
    logic             done_q;

    // Accept a new word only when no conversion is running.
    assign start_o  = load_i && (phase_q == PH_IDLE);
    assign active_o = (phase_q == PH_RUN);
    assign last_o   = active_o && (left_q == '0);
    assign done_o   = done_q;

    // Phase and remaining-bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            left_q  <= '0;
        end else if (start_o) begin
            phase_q <= PH_RUN;
            left_q  <= CNT_FIRST;
        end else if (last_o) begin
            phase_q <= PH_IDLE;
        end else if (active_o) begin
            left_q <= left_q - 1'b1;
        end
    end

    // One-clock done pulse after the final charging cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= last_o;
        end
    end

    // R1: an accepted load starts a run at the next edge.
    p_start_runs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> active_o);

    // R6: a strobe during a run neither restarts nor stops the count.
    p_load_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !last_o && load_i) |=> (active_o && left_q == $past(left_q) - 1'b1));

    // R5: done lasts one cycle only.
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: done is always preceded by the final charging cycle.
    p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(active_o) && !active_o) || start_o || active_o);

endmodule

// File: rtl/drc_shifter.sv
// Module: drc_shifter
// Holds the serial part of the word and presents it LSB first.
// Assumes: load and shift never coincide (sequencer guarantees it).
module drc_shifter #(
    parameter int SER_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [SER_W-1:0] bits_i,
    output logic             bit_o
);

    logic [SER_W-1:0] sh_q;

    // Capture on load, move the next bit into position on each active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= bits_i;
        end else if (shift_i) begin
            sh_q <= sh_q >> 1;
        end
    end

    assign bit_o = sh_q[0];

endmodule

// File: rtl/drc_ref_decoder.sv
// Module: drc_ref_decoder
// Turns interval index plus current serial bit into one-hot switch enables.
// Assumes: index < 2**IDX_W, so index+1 is always a valid reference.
module drc_ref_decoder #(
    parameter int IDX_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic                bit_i,
    output logic [(1<<IDX_W):0] ref_en_o
);

    localparam int NUM_REF = (1 << IDX_W) + 1;
    localparam int SEL_W   = IDX_W + 1;

    logic [SEL_W-1:0] sel;

    // Lower bound for a 0 bit, upper bound for a 1 bit.
    assign sel = {1'b0, idx_i} + SEL_W'(bit_i);

    // One comparator per reference switch.
    for (genvar j = 0; j < NUM_REF; j++) begin : g_sw
        assign ref_en_o[j] = active_i && (sel == SEL_W'(j));
    end

    // R4: exactly one switch while charging.
    p_one_switch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> ($countones(ref_en_o) == 1));

    // R4: no switch while idle.
    p_idle_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |-> (ref_en_o == '0));

    // R3: the closed switch lies on a bound of the selected interval.
    p_in_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> (((ref_en_o >> idx_i) & NUM_REF'(3)) != '0));

endmodule

// File: rtl/divrange_col_ctrl.sv
// Module: divrange_col_ctrl (top)
// Divided-range column converter controller. The MSBs pick an interval
// between two adjacent references, and the LSBs drive one of the two
// references per charging cycle, LSB first.
// Assumes: synchronous active-low reset; load_i is a level sampled at edges.
module divrange_col_ctrl #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [DATA_W-1:0]   data_i,
    output logic [(1<<IDX_W):0] ref_en_o,
    output logic                charge_o,
    output logic                done_o
);

    localparam int SER_W = DATA_W - IDX_W;

    logic             start;
    logic             active;
    logic             last;
    logic             ser_bit;
    logic [IDX_W-1:0] idx_q;

    drc_sequencer #(.SER_W(SER_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .start_o  (start),
        .active_o (active),
        .last_o   (last),
        .done_o   (done_o)
    );

    drc_shifter #(.SER_W(SER_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start),
        .shift_i (active),
        .bits_i  (data_i[SER_W-1:0]),
        .bit_o   (ser_bit)
    );

    // Interval index latch: written only when a conversion is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (start) begin
            idx_q <= data_i[DATA_W-1:SER_W];
        end
    end

    drc_ref_decoder #(.IDX_W(IDX_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .idx_i    (idx_q),
        .bit_i    (ser_bit),
        .ref_en_o (ref_en_o)
    );

    assign charge_o = active;

    // R2: the interval stays fixed between charging cycles of one run.
    p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |=> $stable(idx_q));

    // R7: outputs are clear the cycle after reset is applied.
    p_reset_clear_r7: assert property (@(posedge clk)
        $past(!rst_n) |-> (ref_en_o == '0 && !charge_o && !done_o));

endmodule

// File: tb/divrange_col_ctrl_bench.sv
module divrange_col_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam logic [7:0] VEC [NV] = '{8'h00, 8'hFF, 8'h3F, 8'hC0,
                                        8'h5A, 8'hA5, 8'h81, 8'h7E};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [7:0] data_i = '0;
    logic [4:0] ref_en_o;
    logic       charge_o;
    logic       done_o;

    int checks = 0;
    int failures = 0;

    divrange_col_ctrl u_divrange_col_ctrl (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .data_i(data_i),
        .ref_en_o(ref_en_o), .charge_o(charge_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] exp_ref(input logic [7:0] d, input int k);
        return 5'(1) << (d[7:6] + 3'(d[k]));
    endfunction

    // Drive a one-cycle load; returns at the negedge showing active cycle 0.
    task automatic do_load(input logic [7:0] d);
        load_i = 1'b1; data_i = d;
        @(negedge clk);
        load_i = 1'b0; data_i = ~d;
    endtask

    // Check six charging cycles, then the done cycle (returns at its negedge).
    task automatic check_run(input logic [7:0] d, input bit poke);
        for (int k = 0; k < 6; k++) begin
            check("R1 charge", 32'(charge_o), 1);
            check("R2/R3 ref_en", 32'(ref_en_o), 32'(exp_ref(d, k)));
            check("R4 onehot", 32'($countones(ref_en_o)), 1);
            check("R5 done low", 32'(done_o), 0);
            if (poke && k == 2) begin
                load_i = 1'b1; data_i = 8'h6C;  // R6 strobe mid-run
            end
            @(negedge clk);
            load_i = 1'b0;
        end
        check("R5 done high", 32'(done_o), 1);
        check("R1 charge off", 32'(charge_o), 0);
        check("R4 idle zero", 32'(ref_en_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7 reset state
        check("R7 ref_en reset", 32'(ref_en_o), 0);
        check("R7 charge reset", 32'(charge_o), 0);
        check("R7 done reset", 32'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            do_load(VEC[v]);
            check_run(VEC[v], 1'b0);
            @(negedge clk);
            check("R5 done single", 32'(done_o), 0);
            check("R1 stays idle", 32'(charge_o), 0);
        end

        // R6: strobe and data change mid-run are ignored
        do_load(8'hB3);
        check_run(8'hB3, 1'b1);
        @(negedge clk);
        check("R6 no restart", 32'(charge_o), 0);

        // R8: load in the done cycle starts immediately
        do_load(8'h4D);
        check_run(8'h4D, 1'b0);
        do_load(8'hE2);
        check_run(8'hE2, 1'b0);
        @(negedge clk);

        // R7: reset mid-run abandons the conversion
        do_load(8'hFF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 abort ref_en", 32'(ref_en_o), 0);
        check("R7 abort charge", 32'(charge_o), 0);
        rst_n = 1'b1;
        repeat (7) begin
            check("R7 stays idle", 32'(charge_o), 0);
            check("R7 no done", 32'(done_o), 0);
            @(negedge clk);
        end
        do_load(8'h96);
        check_run(8'h96, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule